// File: doc/BRIEF.md
# Modem Control and Status Logic with Loopback

This block sits beside the register file of a 16550-style serial port. It holds the modem control byte (the driven handshake outputs and the loopback switch) and builds the modem status byte. The status byte carries four line levels and four sticky change flags. The host writes the control byte through a write strobe and reads the status byte through a read strobe. The read strobe clears the change flags. A single flag output tells the interrupt logic that at least one change flag is set.

A two-state mode machine follows the loopback bit. It has two states:
- `MODE_EXT`: the external clear-to-send and ring pins feed the status lines, and carrier-detect and data-set-ready read as asserted.
- `MODE_LOOP`: the four control outputs feed the status lines, and the external request-to-send and data-terminal-ready pins are held low.

A control write with bit 4 set moves `MODE_EXT` to `MODE_LOOP`. A control write with bit 4 clear moves `MODE_LOOP` back to `MODE_EXT`. Any other cycle keeps the state. The status lines are re-evaluated every clock, and they take their new value on the same edge as a control write. Every pin is active-high and is assumed to be synchronous to `clk`.

Top module: `mdm_status_top`

## Requirements
- R1: A control write stores only data bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback). `mcr_q` bits 7:5 always read 0, and the stored value shows on `mcr_q` the cycle after the write edge.
- R2: After reset, `mcr_q` is 0x00, all change flags are 0, `msr_q` is 0xA0 with both pins low, `delta_irq` is low and all four control output pins are low.
- R3: In `MODE_EXT`, the status byte has the following bits:
  - bit 7 (carrier detect) and bit 5 (data set ready) read 1;
  - bit 4 (clear to send) follows `pin_cts`;
  - bit 6 (ring) follows `pin_ri`.

  A pin change shows one edge later.
- R4: In `MODE_LOOP`, the status lines take their values from the control bits:
  - bit 4 takes RTS;
  - bit 5 takes DTR;
  - bit 6 takes OUT1;
  - bit 7 takes OUT2.

  The external pins have no effect. `rts_out` and `dtr_out` are 0, and `out1_out` and `out2_out` follow their control bits.
- R5: In `MODE_EXT`, `dtr_out` equals control bit 0, `rts_out` equals bit 1, `out1_out` equals bit 2 and `out2_out` equals bit 3.
- R6: Any change of the clear-to-send line sets status bit 0. Any change of data-set-ready sets bit 1. Any change of carrier-detect sets bit 3. This holds whether the change comes from a write, a mode switch or a pin.
- R7: Status bit 2 is set only when the ring line goes from 1 to 0. A 0 to 1 ring transition sets nothing.
- R8: Change flags are sticky. A status update never clears a flag, and flags accumulate across writes and pin changes.
- R9: During a read-strobe cycle, `msr_q` shows the current byte. After that edge, bits 3:0 are 0 unless a new change arrived, and bits 7:4 are unaffected.
- R10: A line change in the same cycle as a read strobe sets its flag after the edge, even though the older flags are cleared.
- R11: `delta_irq` is high exactly when any of `msr_q` bits 3:0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcr_wr | input | 1 | Control-byte write strobe |
| mcr_wdata | input | 8 | Control-byte write data |
| msr_rd | input | 1 | Status-byte read strobe (clears change flags) |
| pin_cts | input | 1 | External clear-to-send level |
| pin_ri | input | 1 | External ring level |
| msr_q | output | 8 | Status byte: lines in 7:4, change flags in 3:0 |
| mcr_q | output | 8 | Control byte readback |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Data-terminal-ready pin |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| delta_irq | output | 1 | Any change flag set |

## Verification
The clearing read of the status byte can coincide with a fresh line change, so a new flag must be set in the same cycle that older flags are wiped. The bench provokes this case by strobing the read while dropping `pin_cts` in the same cycle. It then expects only the clear-to-send flag after the edge, with `delta_irq` still high. A second collision is a control write that switches mode and moves several lines at once. That case is judged by expecting every affected flag, together with the older sticky ones, in the byte after the edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int REG_W    = 8;
    localparam int LINE_W   = 4;
    localparam int KEEP_W   = 5;
    localparam int LOOP_BIT = 4;

    typedef enum logic {
        MODE_EXT  = 1'b0,
        MODE_LOOP = 1'b1
    } mode_e;

    // bit order matches status byte 7:4 and flag bits 3:0
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    // bit order matches control byte 3:0
    typedef struct packed {
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam lines_t LINES_AT_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl_d,
    output mode_e            mode_d,
    output ctl_t             ctl_q,
    output mode_e            mode_q,
    output logic             rts_pin,
    output logic             dtr_pin,
    output logic             out1_pin,
    output logic             out2_pin
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[REG_W-1:KEEP_W];

    // next-state of the mode machine
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_EXT:  if (wr && wdata[LOOP_BIT])  mode_d = MODE_LOOP;
            MODE_LOOP: if (wr && !wdata[LOOP_BIT]) mode_d = MODE_EXT;
            default:   mode_d = MODE_EXT;
        endcase
    end

    assign ctl_d = wr ? ctl_t'(wdata[LINE_W-1:0]) : ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_EXT;
            ctl_q  <= '0;
        end else begin
            mode_q <= mode_d;
            ctl_q  <= ctl_d;
        end
    end

    // outputs per state
    always_comb begin
        out1_pin = ctl_q.out1;
        out2_pin = ctl_q.out2;
        unique case (mode_q)
            MODE_EXT: begin
                rts_pin = ctl_q.rts;
                dtr_pin = ctl_q.dtr;
            end
            MODE_LOOP: begin
                rts_pin = 1'b0;
                dtr_pin = 1'b0;
            end
            default: begin
                rts_pin = 1'b0;
                dtr_pin = 1'b0;
            end
        endcase
    end

    a_r1_loop_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((mode_q == MODE_LOOP) == $past(wdata[LOOP_BIT])));
    a_r1_ctl_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctl_q == $past(wdata[LINE_W-1:0])));
    a_r4_loop_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOOP) |-> (!rts_pin && !dtr_pin));
    a_r5_ext_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EXT) |-> (rts_pin == ctl_q.rts && dtr_pin == ctl_q.dtr));
endmodule

// File: rtl/mdm_line_sel.sv
module mdm_line_sel
    import mdm_pkg::*;
(
    input  mode_e  mode,
    input  ctl_t   ctl,
    input  logic   pin_cts,
    input  logic   pin_ri,
    output lines_t lines
);
    always_comb begin
        unique case (mode)
            MODE_LOOP: begin
                lines.cts = ctl.rts;
                lines.dsr = ctl.dtr;
                lines.ri  = ctl.out1;
                lines.dcd = ctl.out2;
            end
            MODE_EXT: begin
                lines.cts = pin_cts;
                lines.dsr = 1'b1;
                lines.ri  = pin_ri;
                lines.dcd = 1'b1;
            end
            default: lines = LINES_AT_RESET;
        endcase
    end
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lines_t            lines_d,
    input  logic              rd_clr,
    output lines_t            lines_q,
    output logic [LINE_W-1:0] delta_q
);
    lines_t             events;
    logic [LINE_W-1:0]  delta_d;

    always_comb begin
        events.cts = lines_d.cts ^ lines_q.cts;
        events.dsr = lines_d.dsr ^ lines_q.dsr;
        events.dcd = lines_d.dcd ^ lines_q.dcd;
        events.ri  = lines_q.ri & ~lines_d.ri;
        delta_d    = (rd_clr ? '0 : delta_q) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= LINES_AT_RESET;
            delta_q <= '0;
        end else begin
            lines_q <= lines_d;
            delta_q <= delta_d;
        end
    end

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr ##1 $stable(lines_q) |-> (delta_q == '0));
    a_r7_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lines_q.ri) && !lines_q.ri) |-> delta_q[2]);
    a_r6_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_q.cts != $past(lines_q.cts)) |-> delta_q[0]);
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_wr,
    input  logic [REG_W-1:0] mcr_wdata,
    input  logic             msr_rd,
    input  logic             pin_cts,
    input  logic             pin_ri,
    output logic [REG_W-1:0] msr_q,
    output logic [REG_W-1:0] mcr_q,
    output logic             rts_out,
    output logic             dtr_out,
    output logic             out1_out,
    output logic             out2_out,
    output logic             delta_irq
);
    ctl_t              ctl_d, ctl_q;
    mode_e             mode_d, mode_q;
    lines_t            lines_d, lines_q;
    logic [LINE_W-1:0] delta_q;

    mdm_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (mcr_wr),
        .wdata    (mcr_wdata),
        .ctl_d    (ctl_d),
        .mode_d   (mode_d),
        .ctl_q    (ctl_q),
        .mode_q   (mode_q),
        .rts_pin  (rts_out),
        .dtr_pin  (dtr_out),
        .out1_pin (out1_out),
        .out2_pin (out2_out)
    );

    mdm_line_sel u_sel (
        .mode    (mode_d),
        .ctl     (ctl_d),
        .pin_cts (pin_cts),
        .pin_ri  (pin_ri),
        .lines   (lines_d)
    );

    mdm_delta_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_d (lines_d),
        .rd_clr  (msr_rd),
        .lines_q (lines_q),
        .delta_q (delta_q)
    );

    assign mcr_q     = {{(REG_W-KEEP_W){1'b0}}, (mode_q == MODE_LOOP), ctl_q};
    assign msr_q     = {lines_q, delta_q};
    assign delta_irq = |delta_q;

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[REG_W-1:KEEP_W] == '0);
    a_r3_forced_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_q[LOOP_BIT] |-> (msr_q[7] && msr_q[5]));
    a_r4_loop_rts_map: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[LOOP_BIT] |-> (msr_q[4] == mcr_q[1] && msr_q[7] == mcr_q[3]));
    a_r11_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        delta_irq == (msr_q[3:0] != '0));
endmodule

// File: tb/sim_mdm_status_top.sv
module sim_mdm_status_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcr_wr = 1'b0;
    logic [7:0] mcr_wdata = '0;
    logic       msr_rd = 1'b0;
    logic       pin_cts = 1'b0;
    logic       pin_ri = 1'b0;
    logic [7:0] msr_q, mcr_q;
    logic       rts_out, dtr_out, out1_out, out2_out, delta_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] mcr;
        logic [7:0] msr;
        logic [3:0] pins;   // {rts, dtr, out1, out2}
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    mdm_status_top u0 (
        .clk(clk), .rst_n(rst_n), .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata),
        .msr_rd(msr_rd), .pin_cts(pin_cts), .pin_ri(pin_ri),
        .msr_q(msr_q), .mcr_q(mcr_q), .rts_out(rts_out), .dtr_out(dtr_out),
        .out1_out(out1_out), .out2_out(out2_out), .delta_irq(delta_irq)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: compares one expected item per negedge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (mcr_q !== e.mcr || msr_q !== e.msr || delta_irq !== e.irq ||
                {rts_out, dtr_out, out1_out, out2_out} !== e.pins) begin
                errors++;
                $display("FAIL %s: mcr=%h msr=%h pins=%b irq=%b expected mcr=%h msr=%h pins=%b irq=%b",
                         e.tag, mcr_q, msr_q, {rts_out, dtr_out, out1_out, out2_out}, delta_irq,
                         e.mcr, e.msr, e.pins, e.irq);
            end
        end
    end

    // driver: one cycle of stimulus, then queue the expected result
    task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic cts, input logic ri,
                        input logic [7:0] emcr, input logic [7:0] emsr,
                        input logic [3:0] epins, input string tag);
        exp_t e;
        @(negedge clk);
        mcr_wr = wr; mcr_wdata = wd; msr_rd = rd; pin_cts = cts; pin_ri = ri;
        @(posedge clk);
        e.mcr = emcr; e.msr = emsr; e.pins = epins; e.irq = (emsr[3:0] != 4'h0); e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        mcr_wr = 1'b0; msr_rd = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R2 reset state
        step(0, 8'h00, 0, 0, 0, 8'h00, 8'hA0, 4'b0000, "R2 reset");
        // R1 R4 R6 loopback on, upper bits dropped, cts rises
        step(1, 8'hFF, 0, 0, 0, 8'h1F, 8'hF1, 4'b0011, "R1 R4 R6 write FF");
        // R9 read clears flags
        step(0, 8'h00, 1, 0, 0, 8'h1F, 8'hF0, 4'b0011, "R9 read clears");
        // R7 ring trailing edge in loopback
        step(1, 8'h1B, 0, 0, 0, 8'h1B, 8'hB4, 4'b0001, "R7 ring fall");
        // R7 R8 ring rise sets nothing, flag kept
        step(1, 8'h1F, 0, 0, 0, 8'h1F, 8'hF4, 4'b0011, "R7 R8 ring rise");
        step(0, 8'h00, 1, 0, 0, 8'h1F, 8'hF0, 4'b0011, "R9 read");
        // R3 R6 leave loopback: cts and ri fall
        step(1, 8'h00, 0, 0, 0, 8'h00, 8'hA5, 4'b0000, "R3 R6 exit loop");
        step(0, 8'h00, 1, 0, 0, 8'h00, 8'hA0, 4'b0000, "R9 read");
        // R5 external pins follow control bits
        step(1, 8'h03, 0, 0, 0, 8'h03, 8'hA0, 4'b1100, "R5 rts dtr");
        step(1, 8'h0C, 0, 0, 0, 8'h0C, 8'hA0, 4'b0011, "R5 out1 out2");
        step(1, 8'h03, 0, 0, 0, 8'h03, 8'hA0, 4'b1100, "R5 restore");
        // R3 R6 pin cts rises
        step(0, 8'h00, 0, 1, 0, 8'h03, 8'hB1, 4'b1100, "R3 R6 pin cts");
        // R7 pin ri rises: no flag
        step(0, 8'h00, 0, 1, 1, 8'h03, 8'hF1, 4'b1100, "R7 pin ri rise");
        // R7 R8 pin ri falls
        step(0, 8'h00, 0, 1, 0, 8'h03, 8'hB5, 4'b1100, "R7 R8 pin ri fall");
        // R10 read collides with cts change
        step(0, 8'h00, 1, 0, 0, 8'h03, 8'hA1, 4'b1100, "R10 read with change");
        // R11 irq drops after clean read
        step(0, 8'h00, 1, 0, 0, 8'h03, 8'hA0, 4'b1100, "R11 irq low");
        // R4 R6 loop with all zero: dsr and dcd fall
        step(1, 8'h10, 0, 0, 0, 8'h10, 8'h0A, 4'b0000, "R4 R6 loop zero");
        // R4 external pin ignored in loopback
        step(0, 8'h00, 0, 1, 1, 8'h10, 8'h0A, 4'b0000, "R4 pins ignored");
        // R1 R8 upper bits dropped, return to ext, flags accumulate
        step(1, 8'hE1, 0, 1, 0, 8'h01, 8'hBB, 4'b0100, "R1 R8 write E1");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule